// File: doc/BRIEF.md
# Banked Memory Map Controller

This block holds one 8-bit memory control byte for a machine with a 16-bit address space. It also contains the address decoder that the byte steers. For every bus access it names the single target that answers: main RAM, the operating-system ROM, the BASIC ROM, a plug-in cartridge, the self-test ROM, the hardware register hole, or one of four extended RAM banks. It also produces the address that target should see.

Two masters share the bus: the CPU and a video DMA agent. A master-select input tells the decoder which one is accessing, because each master has its own enable for the banked 16 KB window. The decoded target and the translated address are registered, so they appear one clock after the access is presented. The control byte is written through a simple write strobe and is always visible on a read-data output.

Top module: `bank_map_ctrl`

## Requirements
- R1: After synchronous reset the control byte reads 0xFF and `region_sel` is all zero.
- R2: A write strobe loads `reg_wr_data` into the control byte; `reg_rd_data` shows the new value from the next clock onward.
- R3: Addresses 0xD000–0xD7FF always select the hardware hole (`region_sel` bit 5), whatever the control byte holds.
- R4: Elsewhere in 0xC000–0xFFFF, control bit 0 set selects the OS ROM (bit 1) and bit 0 clear selects RAM (bit 0).
- R5: With no cartridge, 0xA000–0xBFFF selects the BASIC ROM (bit 2) when control bit 1 is clear, and RAM when it is set.
- R6: With `cart_present` high, 0xA000–0xBFFF selects the cartridge (bit 3) and control bit 1 has no effect.
- R7: For a CPU access (`acc_video`=0) to 0x4000–0x7FFF with control bit 4 set, the target is the extended bank (bit 6) and `tgt_addr` = (control[3:2] << 14) | addr[13:0]. With bit 4 clear the target is RAM.
- R8: A video access (`acc_video`=1) to 0x4000–0x7FFF uses control bit 5 in the same way, independently of bit 4.
- R9: A CPU access to 0x5000–0x57FF with control bit 7 clear selects the self-test ROM (bit 4) with `tgt_addr` = 0xD000 | addr[10:0]. This takes priority over the bank window. Video accesses never select it.
- R10: Results appear on the clock after `acc_valid`. `region_sel` is one-hot for a valid access and zero for an idle cycle. Targets other than the bank and self-test ROM get `tgt_addr` equal to the access address.
- R11: An access presented in the same cycle as a register write is decoded with the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control byte write strobe |
| reg_wr_data | input | 8 | Control byte write value |
| reg_rd_data | output | 8 | Current control byte |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 16 | Access address |
| acc_video | input | 1 | 1 = video DMA master, 0 = CPU |
| cart_present | input | 1 | Cartridge inserted |
| region_sel | output | 7 | One-hot target, registered |
| tgt_addr | output | 16 | Address for the target, registered |

## Verification
A corrupted control byte shows at the ports at once on `reg_rd_data`. It also shows on the first access that reaches a window the bad bit governs, one clock after that access. A wrong priority between overlapping windows appears as a wrong one-hot bit: self-test against bank, hole against OS ROM, cartridge against BASIC. A bad bank field appears only in the upper bits of `tgt_addr`, so the bench checks the translated address as well as the select. Boundary addresses at each window edge expose off-by-one range decodes in a single access.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int BANK_W  = 2;
  localparam int WIN_W   = 14;
  localparam int ST_W    = 11;
  localparam int RG_NUM  = 7;

  localparam int RG_RAM   = 0;
  localparam int RG_OS    = 1;
  localparam int RG_BASIC = 2;
  localparam int RG_CART  = 3;
  localparam int RG_ST    = 4;
  localparam int RG_HW    = 5;
  localparam int RG_EXT   = 6;

  // base of the hole where the self-test image physically lives
  localparam logic [ADDR_W-1:0] ST_PHYS_BASE = 16'hD000;

  typedef struct packed {
    logic              st_ram;     // 1: RAM at self-test window
    logic              spare;
    logic              vid_bank;   // video master bank enable
    logic              cpu_bank;   // CPU bank enable
    logic [BANK_W-1:0] bank;       // extended bank number
    logic              basic_ram;  // 1: RAM instead of BASIC
    logic              os_rom;     // 1: OS ROM mapped
  } ctl_t;
endpackage

// File: rtl/bmc_ctrl_reg.sv
module bmc_ctrl_reg
  import bmc_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_VAL;
    else if (wr_en) q <= wr_data;
  end

  assign ctl = ctl_t'(q);
endmodule

// File: rtl/bmc_decode.sv
module bmc_decode
  import bmc_pkg::*;
(
  input  ctl_t              ctl,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              video,
  input  logic              cart,
  output logic [RG_NUM-1:0] sel,
  output logic [ADDR_W-1:0] tgt
);
  logic in_hole, in_top, in_basic, in_win, in_st, bank_on;
  logic unused_spare;

  assign unused_spare = ctl.spare;

  assign in_hole  = (addr[15:11] == 5'b11010);
  assign in_top   = (addr[15:14] == 2'b11);
  assign in_basic = (addr[15:13] == 3'b101);
  assign in_win   = (addr[15:14] == 2'b01);
  assign in_st    = (addr[15:11] == 5'b01010);
  assign bank_on  = video ? ctl.vid_bank : ctl.cpu_bank;

  always_comb begin
    sel = '0;
    tgt = addr;
    if (!valid) begin
      sel = '0;
    end else if (in_hole) begin
      sel[RG_HW] = 1'b1;
    end else if (in_top) begin
      if (ctl.os_rom) sel[RG_OS]  = 1'b1;
      else            sel[RG_RAM] = 1'b1;
    end else if (in_basic) begin
      if (cart)                sel[RG_CART]  = 1'b1;
      else if (!ctl.basic_ram) sel[RG_BASIC] = 1'b1;
      else                     sel[RG_RAM]   = 1'b1;
    end else if (in_st && !video && !ctl.st_ram) begin
      sel[RG_ST] = 1'b1;
      tgt = ST_PHYS_BASE | {{(ADDR_W-ST_W){1'b0}}, addr[ST_W-1:0]};
    end else if (in_win && bank_on) begin
      sel[RG_EXT] = 1'b1;
      tgt = {ctl.bank, addr[WIN_W-1:0]};
    end else begin
      sel[RG_RAM] = 1'b1;
    end
  end
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bmc_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_video,
  input  logic              cart_present,
  output logic [RG_NUM-1:0] region_sel,
  output logic [ADDR_W-1:0] tgt_addr
);
  ctl_t              ctl;
  logic [RG_NUM-1:0] sel_d;
  logic [ADDR_W-1:0] tgt_d;

  bmc_ctrl_reg #(.RESET_VAL(RESET_VAL)) reg_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data), .ctl(ctl)
  );

  bmc_decode dec_i (
    .ctl(ctl), .valid(acc_valid), .addr(acc_addr), .video(acc_video),
    .cart(cart_present), .sel(sel_d), .tgt(tgt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      region_sel <= '0;
      tgt_addr   <= '0;
    end else begin
      region_sel <= sel_d;
      tgt_addr   <= tgt_d;
    end
  end

  assign reg_rd_data = ctl;
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk
  import bmc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_video,
  input logic              cart_present,
  input logic [RG_NUM-1:0] region_sel,
  input logic [ADDR_W-1:0] tgt_addr
);
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> region_sel == '0); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> $countones(region_sel) == 1); // R10
  AST_HOLE_FIXED: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_addr[15:11] == 5'b11010 |=> region_sel[RG_HW]); // R3
  AST_REG_ECHO: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> reg_rd_data == $past(reg_wr_data)); // R2
  AST_CART_OWNS: assert property (@(posedge clk) disable iff (rst)
    acc_valid && cart_present && acc_addr[15:13] == 3'b101 |=> region_sel[RG_CART]); // R6
  AST_BANK_OFFSET: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!region_sel[RG_EXT] || tgt_addr[WIN_W-1:0] == $past(acc_addr[WIN_W-1:0]))); // R7
  AST_VIDEO_NO_ST: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_video |=> !region_sel[RG_ST]); // R9
endmodule

bind bank_map_ctrl bmc_chk chk_i (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
  .reg_rd_data(reg_rd_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_video(acc_video), .cart_present(cart_present),
  .region_sel(region_sel), .tgt_addr(tgt_addr)
);

// File: tb/bank_map_ctrl_tb.sv
`timescale 1ns/1ps
module bank_map_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wr_data = '0;
  logic [7:0]  reg_rd_data;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_video = 1'b0;
  logic        cart_present = 1'b0;
  logic [6:0]  region_sel;
  logic [15:0] tgt_addr;

  int total = 0;
  int bad = 0;

  localparam logic [6:0] S_RAM = 7'h01, S_OS = 7'h02, S_BAS = 7'h04,
                         S_CART = 7'h08, S_ST = 7'h10, S_HW = 7'h20, S_EXT = 7'h40;

  always #2.5 clk = ~clk;

  bank_map_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_video(acc_video), .cart_present(cart_present),
    .region_sel(region_sel), .tgt_addr(tgt_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // presents one access, samples registered result one clock later
  task automatic acc(input logic [15:0] a, input logic vid, input logic cart,
                     input string req, input logic [6:0] es, input logic [15:0] ea);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_video = vid; cart_present = cart;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req, int'(region_sel), int'(es));
    chk(req, int'(tgt_addr), int'(ea));
  endtask

  task automatic t_reset();
    chk("R1", int'(reg_rd_data), 32'hFF);
    chk("R1", int'(region_sel), 0);
    acc(16'h4000, 1'b0, 1'b0, "R1", S_EXT, 16'hC000);
  endtask

  task automatic t_reg();
    wr(8'h5A); chk("R2", int'(reg_rd_data), 32'h5A);
    wr(8'hA5); chk("R2", int'(reg_rd_data), 32'hA5);
  endtask

  task automatic t_hole();
    wr(8'hFF);
    acc(16'hD000, 1'b0, 1'b0, "R3", S_HW, 16'hD000);
    acc(16'hD7FF, 1'b1, 1'b0, "R3", S_HW, 16'hD7FF);
    wr(8'h00);
    acc(16'hD400, 1'b0, 1'b0, "R3", S_HW, 16'hD400);
    acc(16'hD800, 1'b0, 1'b0, "R4", S_RAM, 16'hD800);
  endtask

  task automatic t_os();
    wr(8'h01);
    acc(16'hC000, 1'b0, 1'b0, "R4", S_OS, 16'hC000);
    acc(16'hFFFF, 1'b1, 1'b0, "R4", S_OS, 16'hFFFF);
    acc(16'hCFFF, 1'b0, 1'b0, "R4", S_OS, 16'hCFFF);
    wr(8'h00);
    acc(16'hC000, 1'b0, 1'b0, "R4", S_RAM, 16'hC000);
  endtask

  task automatic t_basic();
    wr(8'h00);
    acc(16'hA000, 1'b0, 1'b0, "R5", S_BAS, 16'hA000);
    acc(16'h9FFF, 1'b0, 1'b0, "R5", S_RAM, 16'h9FFF);
    wr(8'h02);
    acc(16'hBFFF, 1'b0, 1'b0, "R5", S_RAM, 16'hBFFF);
  endtask

  task automatic t_cart();
    wr(8'h00);
    acc(16'hA000, 1'b0, 1'b1, "R6", S_CART, 16'hA000);
    wr(8'h02);
    acc(16'hBFFF, 1'b0, 1'b1, "R6", S_CART, 16'hBFFF);
    acc(16'h9FFF, 1'b0, 1'b1, "R6", S_RAM, 16'h9FFF);
    acc(16'hC000, 1'b0, 1'b1, "R6", S_RAM, 16'hC000);
  endtask

  task automatic t_bank_cpu();
    wr(8'h98); // st off, cpu bank on, bank 2
    acc(16'h4123, 1'b0, 1'b0, "R7", S_EXT, 16'h8123);
    acc(16'h7FFF, 1'b0, 1'b0, "R7", S_EXT, 16'hBFFF);
    acc(16'h4123, 1'b1, 1'b0, "R8", S_RAM, 16'h4123);
    acc(16'h3FFF, 1'b0, 1'b0, "R7", S_RAM, 16'h3FFF);
    acc(16'h8000, 1'b0, 1'b0, "R7", S_RAM, 16'h8000);
    wr(8'h88);
    acc(16'h4123, 1'b0, 1'b0, "R7", S_RAM, 16'h4123);
  endtask

  task automatic t_bank_video();
    wr(8'hA4); // video bank on, bank 1
    acc(16'h7FFF, 1'b1, 1'b0, "R8", S_EXT, 16'h7FFF);
    acc(16'h4000, 1'b1, 1'b0, "R8", S_EXT, 16'h4000);
    acc(16'h7FFF, 1'b0, 1'b0, "R8", S_RAM, 16'h7FFF);
  endtask

  task automatic t_selftest();
    wr(8'h1C); // st mapped, cpu bank on, bank 3
    acc(16'h5000, 1'b0, 1'b0, "R9", S_ST, 16'hD000);
    acc(16'h57FF, 1'b0, 1'b0, "R9", S_ST, 16'hD7FF);
    acc(16'h5800, 1'b0, 1'b0, "R9", S_EXT, 16'hD800);
    acc(16'h4FFF, 1'b0, 1'b0, "R9", S_EXT, 16'hCFFF);
    wr(8'h3C);
    acc(16'h5000, 1'b1, 1'b0, "R9", S_EXT, 16'hD000);
    wr(8'h9C);
    acc(16'h5000, 1'b0, 1'b0, "R9", S_EXT, 16'hD000);
    wr(8'h00);
    acc(16'h5400, 1'b0, 1'b0, "R9", S_ST, 16'hD400);
  endtask

  task automatic t_idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 16'hD000;
    @(negedge clk);
    chk("R10", int'(region_sel), 0);
  endtask

  task automatic t_same_cycle();
    wr(8'h01);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = 8'h00;
    acc_valid = 1'b1; acc_addr = 16'hC000; acc_video = 1'b0; cart_present = 1'b0;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0;
    chk("R11", int'(region_sel), int'(S_OS));
    chk("R11", int'(reg_rd_data), 0);
    acc(16'hC000, 1'b0, 1'b0, "R11", S_RAM, 16'hC000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reg();
        t_hole();
        t_os();
        t_basic();
        t_cart();
        t_bank_cpu();
        t_bank_video();
        t_selftest();
        t_idle();
        t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule